// File: doc/BRIEF.md
# Two-Level Stream Priority Arbiter

This block decides which of eight transfer streams owns a shared bus. Every stream has a request line, an enable bit and a two-bit priority value held inside the arbiter. The winner is the requesting, enabled stream with the highest priority value. When several such streams share that value, the lowest stream number wins. The result is shown as a registered one-hot grant vector and the matching binary index.

Once a stream owns the bus, the bus side holds `bus_busy` high for the length of its beat or burst. The grant stays frozen during that time, so a transaction in progress is never preempted. In any cycle where `bus_busy` is low, or where nobody holds the grant, the arbiter picks again and loads the result on the next clock edge.

Priorities are written through a small write port: a strobe, a stream index and a value. A write only takes effect while the target stream is disabled. Requests from disabled streams are masked before arbitration. The block has no data path, so every pin is a plain control or status signal and there is no valid/ready back-pressure.

Top module: `prio_arb_top`

## Requirements
- R1: After reset `grant` is all zeros, `grant_idx` is 0, and every stream's priority is 0 (lowest).
- R2: `grant` has at most one bit set. When a bit is set, `grant_idx` is its position; when `grant` is zero, `grant_idx` is 0.
- R3: Among enabled requesters, the one with the numerically larger priority value wins (3 highest, 0 lowest), whatever its stream number.
- R4: Among enabled requesters with the same highest priority value, the lowest stream number wins.
- R5: A request from a stream whose `stream_en` bit is 0 is never granted and does not block lower-priority streams.
- R6: A priority write (`prio_wr_en` high, stream `prio_wr_idx`, value `prio_wr_val`) is stored on the clock edge only if `stream_en[prio_wr_idx]` is 0 in that cycle; otherwise it is ignored.
- R7: While `grant` is nonzero and `bus_busy` is high, `grant` and `grant_idx` do not change, whatever happens to requests, enables or priorities.
- R8: In a cycle where `bus_busy` is low or `grant` is zero, the arbitration result is loaded at the next rising edge, with exactly one cycle of latency. With no enabled requests, the loaded grant is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stream_en | input | 8 | Per-stream enable; a 0 masks the request and unlocks priority writes |
| req | input | 8 | Per-stream bus request |
| prio_wr_en | input | 1 | Priority write strobe |
| prio_wr_idx | input | 3 | Stream whose priority is written |
| prio_wr_val | input | 2 | New priority value, 0 lowest to 3 highest |
| bus_busy | input | 1 | Owner's transaction in progress; freezes the grant |
| grant | output | 8 | Registered one-hot grant, zero when idle |
| grant_idx | output | 3 | Index of the granted stream, 0 when idle |

## Verification
The hardest condition to reach from the ports is a priority write that is rejected. The stored priority cannot be read back, so its effect can only be seen in a later arbitration. The bench sets up a two-stream contest that the ignored write would have flipped, makes the write while the stream is enabled, and checks that the original winner still wins. It then disables the stream, repeats the write, and checks that the winner changes. Hold behaviour is reached by raising `bus_busy` in the cycle the grant appears, then changing requests and enables under it.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int unsigned DEF_STREAMS = 8;
  localparam int unsigned DEF_PRIO_W  = 2;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'd0,
    LVL_MED   = 2'd1,
    LVL_HIGH  = 2'd2,
    LVL_VHIGH = 2'd3
  } prio_lvl_e;
endpackage

// File: rtl/prio_arb_regs.sv
module prio_arb_regs #(
  parameter int unsigned N_STREAMS = prio_arb_pkg::DEF_STREAMS,
  parameter int unsigned PRIO_W    = prio_arb_pkg::DEF_PRIO_W,
  localparam int unsigned IDX_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_STREAMS-1:0]        stream_en,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [PRIO_W-1:0]           wr_val,
  output logic [N_STREAMS*PRIO_W-1:0] prio_flat
);
  // One storage field per stream; a write is accepted only while the
  // target stream is disabled.
  for (genvar s = 0; s < N_STREAMS; s++) begin : g_field
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(s)) && !stream_en[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_flat[s*PRIO_W +: PRIO_W] <= '0;
      else if (hit) prio_flat[s*PRIO_W +: PRIO_W] <= wr_val;
    end
  end
endmodule

// File: rtl/prio_arb_level.sv
module prio_arb_level #(
  parameter int unsigned N_STREAMS = prio_arb_pkg::DEF_STREAMS,
  parameter int unsigned PRIO_W    = prio_arb_pkg::DEF_PRIO_W,
  localparam int unsigned N_LEVELS = 1 << PRIO_W
) (
  input  logic [N_STREAMS-1:0]        active,
  input  logic [N_STREAMS*PRIO_W-1:0] prio_flat,
  output logic [N_STREAMS-1:0]        cand
);
  // Per-level membership vectors, then keep the highest non-empty one.
  logic [N_STREAMS-1:0] at_level [N_LEVELS];

  for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
    for (genvar s = 0; s < N_STREAMS; s++) begin : g_str
      assign at_level[l][s] = active[s] &&
                              (prio_flat[s*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
  end

  always_comb begin
    cand = '0;
    for (int l = 0; l < N_LEVELS; l++) begin
      if (|at_level[l]) cand = at_level[l];
    end
  end
endmodule

// File: rtl/prio_arb_fixed.sv
module prio_arb_fixed #(
  parameter int unsigned N_STREAMS = prio_arb_pkg::DEF_STREAMS,
  localparam int unsigned IDX_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic [N_STREAMS-1:0] cand,
  output logic [N_STREAMS-1:0] pick,
  output logic [IDX_W-1:0]     pick_idx
);
  // Lowest set bit wins: isolate it with two's complement.
  assign pick = cand & (~cand + N_STREAMS'(1));

  always_comb begin
    pick_idx = '0;
    for (int s = 0; s < N_STREAMS; s++) begin
      if (pick[s]) pick_idx = IDX_W'(s);
    end
  end
endmodule

// File: rtl/prio_arb_top.sv
module prio_arb_top #(
  parameter int unsigned N_STREAMS = prio_arb_pkg::DEF_STREAMS,
  parameter int unsigned PRIO_W    = prio_arb_pkg::DEF_PRIO_W,
  localparam int unsigned IDX_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_STREAMS-1:0] stream_en,
  input  logic [N_STREAMS-1:0] req,
  input  logic                 prio_wr_en,
  input  logic [IDX_W-1:0]     prio_wr_idx,
  input  logic [PRIO_W-1:0]    prio_wr_val,
  input  logic                 bus_busy,
  output logic [N_STREAMS-1:0] grant,
  output logic [IDX_W-1:0]     grant_idx
);
  logic [N_STREAMS*PRIO_W-1:0] prio_flat;
  logic [N_STREAMS-1:0]        active;
  logic [N_STREAMS-1:0]        cand;
  logic [N_STREAMS-1:0]        pick;
  logic [IDX_W-1:0]            pick_idx;
  logic                        rearb;

  prio_arb_regs #(.N_STREAMS(N_STREAMS), .PRIO_W(PRIO_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .stream_en (stream_en),
    .wr_en     (prio_wr_en),
    .wr_idx    (prio_wr_idx),
    .wr_val    (prio_wr_val),
    .prio_flat (prio_flat)
  );

  // Disabled streams never reach arbitration.
  assign active = req & stream_en;

  prio_arb_level #(.N_STREAMS(N_STREAMS), .PRIO_W(PRIO_W)) u_level (
    .active    (active),
    .prio_flat (prio_flat),
    .cand      (cand)
  );

  prio_arb_fixed #(.N_STREAMS(N_STREAMS)) u_fixed (
    .cand     (cand),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  // Re-pick only when the owner has released or nobody owns the bus.
  assign rearb = !bus_busy || (grant == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_idx <= '0;
    end else if (rearb) begin
      grant     <= pick;
      grant_idx <= pick_idx;
    end
  end
endmodule

// File: rtl/prio_arb_checker.sv
module prio_arb_checker #(
  parameter int unsigned N_STREAMS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_STREAMS-1:0] stream_en,
  input logic [N_STREAMS-1:0] req,
  input logic                 bus_busy,
  input logic [N_STREAMS-1:0] grant,
  input logic [IDX_W-1:0]     grant_idx
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[grant_idx]);

  a_r2_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |-> (grant_idx == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && grant != '0) |=> ($stable(grant) && $stable(grant_idx)));

  a_r5_from_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy) |=> ((grant == '0) || ((grant & $past(req & stream_en)) != '0)));

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && (req & stream_en) == '0) |=> (grant == '0));
endmodule

bind prio_arb_top prio_arb_checker #(.N_STREAMS(N_STREAMS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stream_en (stream_en),
  .req       (req),
  .bus_busy  (bus_busy),
  .grant     (grant),
  .grant_idx (grant_idx)
);

// File: tb/test_prio_arb_top.sv
module test_prio_arb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stream_en = '0;
  logic [7:0] req = '0;
  logic       prio_wr_en = 1'b0;
  logic [2:0] prio_wr_idx = '0;
  logic [1:0] prio_wr_val = '0;
  logic       bus_busy = 1'b0;
  logic [7:0] grant;
  logic [2:0] grant_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_arb_top i_prio_arb_top (
    .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .req(req),
    .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx), .prio_wr_val(prio_wr_val),
    .bus_busy(bus_busy), .grant(grant), .grant_idx(grant_idx)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic [7:0]  rq;
    logic [15:0] pr;   // stream s priority in bits [2s+1:2s]
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hFF, 8'h00, 16'h0000, 8'h00},  // R8 no requests
    '{8'hFF, 8'h0A, 16'h0000, 8'h02},  // R4 tie at level 0
    '{8'hFF, 8'h81, 16'hC000, 8'h80},  // R3 stream 7 at level 3
    '{8'hFF, 8'hFF, 16'h6955, 8'h20},  // R3/R4 streams 5,6 at level 2
    '{8'hFE, 8'h03, 16'h0000, 8'h02},  // R5 stream 0 disabled
    '{8'h7F, 8'h81, 16'hC000, 8'h01},  // R5 high-priority stream masked
    '{8'hFF, 8'h0C, 16'h0050, 8'h04},  // R4 tie at level 1
    '{8'h00, 8'hFF, 16'h0000, 8'h00}   // R5 all disabled
  };

  function automatic logic [2:0] idx_of(input logic [7:0] g);
    logic [2:0] r = '0;
    for (int s = 0; s < 8; s++) if (g[s]) r = 3'(s);
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s grant actual=%h expected=%h", tag, act, exp);
    end
    n_cmp++;
    if (grant_idx !== idx_of(exp)) begin
      n_bad++;
      $display("FAIL %s grant_idx actual=%0d expected=%0d", tag, grant_idx, idx_of(exp));
    end
  endtask

  task automatic write_prio(input int s, input logic [1:0] v);
    prio_wr_en = 1'b1; prio_wr_idx = 3'(s); prio_wr_val = v;
    @(negedge clk);
    prio_wr_en = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", grant, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: priorities reset to 0, so a tie falls to the lowest stream
    stream_en = 8'hFF; req = 8'h0A;
    #1 check("R8 not before edge", grant, 8'h00);
    @(negedge clk);
    check("R1 reset prio tie", grant, 8'h02);

    // Table walk: program with streams disabled, then arbitrate
    foreach (VECS[k]) begin
      stream_en = 8'h00; req = 8'h00;
      @(negedge clk);
      for (int s = 0; s < 8; s++) write_prio(s, VECS[k].pr[2*s +: 2]);
      stream_en = VECS[k].en; req = VECS[k].rq;
      @(negedge clk);
      check($sformatf("R3/R4/R5 vec%0d", k), grant, VECS[k].exp);
    end

    // R6: write while enabled is ignored
    stream_en = 8'h00; req = 8'h00;
    @(negedge clk);
    for (int s = 0; s < 8; s++) write_prio(s, 2'd0);
    stream_en = 8'hFF;
    write_prio(7, 2'd3);
    req = 8'h81;
    @(negedge clk);
    check("R6 write ignored while enabled", grant, 8'h01);
    stream_en = 8'h7F;
    write_prio(7, 2'd3);
    stream_en = 8'hFF;
    @(negedge clk);
    check("R6 write taken while disabled", grant, 8'h80);

    // R7: hold under bus_busy
    stream_en = 8'h00; req = 8'h00;
    @(negedge clk);
    for (int s = 0; s < 8; s++) write_prio(s, 2'd0);
    stream_en = 8'hFF; req = 8'h02;
    @(negedge clk);
    check("R8 grant after one cycle", grant, 8'h02);
    bus_busy = 1'b1; req = 8'h03;
    @(negedge clk);
    check("R7 hold vs higher-order request", grant, 8'h02);
    req = 8'h00; stream_en = 8'h01;
    @(negedge clk);
    check("R7 hold with request dropped", grant, 8'h02);
    @(negedge clk);
    check("R7 hold second cycle", grant, 8'h02);
    bus_busy = 1'b0; stream_en = 8'hFF; req = 8'h01;
    @(negedge clk);
    check("R8 re-arbitrate after release", grant, 8'h01);
    req = 8'h00;
    @(negedge clk);
    check("R8 idle gives zero grant", grant, 8'h00);

    // R5: disabled request does not hold back lower priority
    stream_en = 8'h00;
    @(negedge clk);
    write_prio(4, 2'd3);
    stream_en = 8'hEF; req = 8'h18;
    @(negedge clk);
    check("R5 masked high stream", grant, 8'h08);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule